// File: doc/BRIEF.md
# Double-Rate Burst-of-Two Write Port

This block is the write-side front end of a quad-data-rate synchronous SRAM with bursts of two. A write command and its burst address are taken on the rising edge of the main clock `k`. Two data beats follow. The first beat is taken on that same `k` rise. The second beat is taken half a cycle later, on the rise of the complementary clock `k_n`. Each beat brings its own active-low lane-enable mask over 9-bit byte lanes. One command can therefore fully write, partly write or skip each half of the burst on its own.

The two beats are merged into two adjacent words of an internal register-array memory. Beat 0 goes to the even word of the burst pair and beat 1 to the odd word. Both words are committed together on the following `k` rise through a registered stage, so the array never works from the falling edge. The lane count is a parameter: 4 lanes give a 36-bit word and 2 lanes give an 18-bit word. A combinational lookup port brings out one stored word so that the array contents can be observed.

Top module: `qdrw_write_port`

## Requirements
- R1: A write is taken only when `wr_n` is low at a `k` rising edge. When `wr_n` is high, no word changes, whatever the data and masks are.
- R2: Data and mask present at the `k` rise where the command is taken form beat 0. Beat 0 lands in word `{wr_addr, 0}`.
- R3: Data and mask present at the `k_n` rise half a cycle later form beat 1. Beat 1 lands in word `{wr_addr, 1}` of the same command.
- R4: Mask bit i is active low and governs data bits 9*i to 9*i+8. A low bit writes that lane. A high bit leaves that lane's stored value unchanged. An all-low mask writes the whole word.
- R5: A beat whose mask bits are all high is aborted: its word keeps its old value. The other beat of the same burst is still written under its own mask.
- R6: Both words of a burst change on the first `k` rise after the command edge. Before that rise, a lookup returns the old contents.
- R7: Commands on consecutive `k` cycles are all committed, each of them in full. When two commands hit the same lane of the same word, the later one wins.
- R8: While `rst_n` is low at a `k` rise, no command is taken and no pending burst is committed. Memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Main clock; command, address and beat 0 are taken on its rise |
| k_n | input | 1 | Complementary clock; beat 1 is taken on its rise |
| rst_n | input | 1 | Synchronous active-low reset of the pending-write stage |
| wr_n | input | 1 | Active-low write command |
| wr_addr | input | ADDR_W | Burst pair address |
| wr_data | input | LANES*9 | Data for the beat being sampled |
| wr_bw_n | input | LANES | Active-low lane enables for the beat being sampled |
| peek_addr | input | ADDR_W+1 | Word address to look up |
| peek_data | output | LANES*9 | Stored word at `peek_addr` (combinational) |

## Verification
The assertions assume that `rst_n` is held low over the first `k` rise, so that the pending stage is defined before any property is enabled. They also assume that the command, address and beat-0 inputs hold steady across each `k` rise. The stimulus meets both: it keeps reset low for the first cycles, and it changes the beat-0 inputs only in the low phase of `k` and the beat-1 inputs only in the high phase, well away from the edge that samples each. The array is filled with full-mask writes before any partial-lane checks, so every compared lane holds a known value.

// File: rtl/qdrw_pkg.sv
// Package qdrw_pkg: constants shared by the write-port modules.
// Assumes: byte lanes are always 9 bits (8 data bits plus one extra bit).
package qdrw_pkg;
    localparam int LANE_BITS = 9;
endpackage

// File: rtl/qdrw_beat_capture.sv
// Module qdrw_beat_capture: captures the second beat (data and mask) on the
// rise of the complementary clock.
// Assumes: the value is used on the next k rise, half a cycle later.
module qdrw_beat_capture #(
    parameter int LANES  = 4,
    parameter int WORD_W = LANES * qdrw_pkg::LANE_BITS
) (
    input  logic              k_n,
    input  logic [WORD_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    output logic [WORD_W-1:0] q_d,
    output logic [LANES-1:0]  q_bw_n
);
    // Holds beat 1 from one k_n rise to the next.
    always_ff @(posedge k_n) begin
        q_d    <= d;
        q_bw_n <= bw_n;
    end
endmodule

// File: rtl/qdrw_cmd_pipe.sv
// Module qdrw_cmd_pipe: registers the write command, address and beat 0 on
// the k rise, then forms the lane write enables for both beats on the
// following k rise.
// Assumes: beat 1 arrives already registered from the k_n domain.
module qdrw_cmd_pipe #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    parameter int WORD_W = LANES * qdrw_pkg::LANE_BITS
) (
    input  logic              k,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] d0,
    input  logic [LANES-1:0]  bw0_n,
    input  logic [LANES-1:0]  bw1_n,
    output logic              commit,
    output logic [ADDR_W-1:0] base,
    output logic [WORD_W-1:0] data0,
    output logic [LANES-1:0]  we0,
    output logic [LANES-1:0]  we1
);
    logic             pend_q;
    logic [LANES-1:0] bw0_q;

    // Pending flag: cleared by reset, otherwise set by a sampled command.
    always_ff @(posedge k) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= ~wr_n;
    end

    // Address and beat 0 are held until the commit edge.
    always_ff @(posedge k) begin
        base  <= addr;
        data0 <= d0;
        bw0_q <= bw0_n;
    end

    // A commit is blocked while reset is asserted at the commit edge.
    always_comb begin
        commit = pend_q & rst_n;
        we0    = commit ? ~bw0_q : '0;
        we1    = commit ? ~bw1_n : '0;
    end
endmodule

// File: rtl/qdrw_lane_array.sv
// Module qdrw_lane_array: the register-array memory, split into one bank per
// byte lane. Each bank writes the even and the odd word of a burst pair in
// the same cycle.
// Assumes: the even and odd words are always distinct addresses.
module qdrw_lane_array #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    parameter int WORD_W = LANES * qdrw_pkg::LANE_BITS
) (
    input  logic              k,
    input  logic [ADDR_W-1:0] base,
    input  logic [LANES-1:0]  we0,
    input  logic [LANES-1:0]  we1,
    input  logic [WORD_W-1:0] data0,
    input  logic [WORD_W-1:0] data1,
    input  logic [ADDR_W:0]   peek_addr,
    output logic [WORD_W-1:0] peek_data
);
    localparam int LB    = qdrw_pkg::LANE_BITS;
    localparam int DEPTH = 2 ** (ADDR_W + 1);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LB-1:0] bank [DEPTH];

        // Burst-pair write for this lane: beat 0 to the even word, beat 1 to the odd word.
        always_ff @(posedge k) begin
            if (we0[i]) bank[{base, 1'b0}] <= data0[i*LB +: LB];
            if (we1[i]) bank[{base, 1'b1}] <= data1[i*LB +: LB];
        end

        assign peek_data[i*LB +: LB] = bank[peek_addr];
    end
endmodule

// File: rtl/qdrw_write_port.sv
// Module qdrw_write_port: top level of the burst-of-two write port. Beat 0
// is taken on the k rise, beat 1 on the k_n rise, and both are committed to
// the array on the next k rise.
// Assumes: k_n is the inverse of k; rst_n is synchronous to k.
module qdrw_write_port #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    parameter int WORD_W = LANES * qdrw_pkg::LANE_BITS
) (
    input  logic              k,
    input  logic              k_n,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_bw_n,
    input  logic [ADDR_W:0]   peek_addr,
    output logic [WORD_W-1:0] peek_data
);
    logic [WORD_W-1:0] half_d;
    logic [LANES-1:0]  half_bw_n;
    logic              commit;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] data0_q;
    logic [LANES-1:0]  we0;
    logic [LANES-1:0]  we1;

    qdrw_beat_capture #(.LANES(LANES), .WORD_W(WORD_W)) u_half (
        .k_n    (k_n),
        .d      (wr_data),
        .bw_n   (wr_bw_n),
        .q_d    (half_d),
        .q_bw_n (half_bw_n)
    );

    qdrw_cmd_pipe #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pipe (
        .k      (k),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .addr   (wr_addr),
        .d0     (wr_data),
        .bw0_n  (wr_bw_n),
        .bw1_n  (half_bw_n),
        .commit (commit),
        .base   (base_q),
        .data0  (data0_q),
        .we0    (we0),
        .we1    (we1)
    );

    qdrw_lane_array #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .k         (k),
        .base      (base_q),
        .we0       (we0),
        .we1       (we1),
        .data0     (data0_q),
        .data1     (half_d),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );
endmodule

// File: rtl/qdrw_write_port_chk.sv
// Module qdrw_write_port_chk: assertion checker bound into qdrw_write_port.
// Assumes: rst_n is low over the first k rise.
module qdrw_write_port_chk #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5
) (
    input logic              k,
    input logic              rst_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [LANES-1:0]  wr_bw_n,
    input logic              commit,
    input logic [ADDR_W-1:0] base_q,
    input logic [LANES-1:0]  we0,
    input logic [LANES-1:0]  we1
);
    AST_IDLE_NO_WRITE: assert property (@(posedge k) disable iff (!rst_n)
        !commit |-> (we0 == '0 && we1 == '0)); // R1

    AST_COMMIT_NEEDS_CMD: assert property (@(posedge k) disable iff (!rst_n)
        commit |-> !$past(wr_n)); // R1

    AST_BEAT0_BASE: assert property (@(posedge k) disable iff (!rst_n)
        commit |-> base_q == $past(wr_addr)); // R2

    AST_BEAT0_LANES: assert property (@(posedge k) disable iff (!rst_n)
        commit |-> we0 == ~$past(wr_bw_n)); // R4

    AST_BACK_TO_BACK: assert property (@(posedge k) disable iff (!rst_n)
        (!$past(wr_n) && $past(rst_n)) |-> commit); // R7

    // During reset, no lane of either beat may be written.
    always @(posedge k) begin
        if (!rst_n) begin
            AST_RESET_HOLD: assert (we0 == '0 && we1 == '0); // R8
        end
    end
endmodule

bind qdrw_write_port qdrw_write_port_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .k       (k),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .wr_addr (wr_addr),
    .wr_bw_n (wr_bw_n),
    .commit  (commit),
    .base_q  (base_q),
    .we0     (we0),
    .we1     (we1)
);

// File: tb/tb_qdrw_write_port.sv
`timescale 1ns/10ps
// Bench for qdrw_write_port: a behavioural model with per-lane known flags,
// and a full lookup sweep of the array compared against it every cycle.
module tb_qdrw_write_port;
    localparam int LANES = 4;
    localparam int AW    = 5;
    localparam int WW    = LANES * 9;
    localparam int WORDS = 2 ** (AW + 1);

    logic          k = 1'b0;
    logic          k_n;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [LANES-1:0] wr_bw_n = '1;
    logic [AW:0]   peek_addr = '0;
    logic [WW-1:0] peek_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    logic [WW-1:0]    ref_mem [WORDS];
    logic [LANES-1:0] known   [WORDS];
    bit               pend_v = 0;
    logic [AW-1:0]    pend_a;
    logic [WW-1:0]    pend_d0, pend_d1;
    logic [LANES-1:0] pend_m0, pend_m1;
    string            last_tag = "R8";

    assign k_n = ~k;
    always #5 k = ~k;

    qdrw_write_port #(.LANES(LANES), .ADDR_W(AW)) dut (
        .k(k), .k_n(k_n), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_bw_n(wr_bw_n), .peek_addr(peek_addr),
        .peek_data(peek_data)
    );

    task automatic put_word(input logic [AW:0] w, input logic [WW-1:0] d,
                            input logic [LANES-1:0] m);
        for (int i = 0; i < LANES; i++) begin
            if (!m[i]) begin
                ref_mem[w][i*9 +: 9] = d[i*9 +: 9];
                known[w][i] = 1'b1;
            end
        end
    endtask

    // Model of one k rise: commit the pending burst, then take the new command.
    task automatic model_edge(input bit rst_v, input bit cmd, input logic [AW-1:0] a,
                              input logic [WW-1:0] d0, input logic [LANES-1:0] m0);
        if (!rst_v) begin
            pend_v = 0;
        end else begin
            if (pend_v) begin
                put_word({pend_a, 1'b0}, pend_d0, pend_m0);
                put_word({pend_a, 1'b1}, pend_d1, pend_m1);
            end
            pend_v  = cmd;
            pend_a  = a;
            pend_d0 = d0;
            pend_m0 = m0;
        end
    endtask

    // Compares every known lane of every word through the lookup port.
    task automatic sweep(input string tag);
        for (int w = 0; w < WORDS; w++) begin
            if (known[w] != '0) begin
                peek_addr = w[AW:0];
                #0.02;
                checks++;
                for (int i = 0; i < LANES; i++) begin
                    if (known[w][i] && peek_data[i*9 +: 9] !== ref_mem[w][i*9 +: 9]) begin
                        errors++;
                        $display("FAIL %s word %0d lane %0d actual %h expected %h",
                                 tag, w, i, peek_data[i*9 +: 9], ref_mem[w][i*9 +: 9]);
                    end
                end
            end
        end
    endtask

    // One k period, entered shortly after a k fall.
    task automatic cycle(input string tag, input bit rst_v, input bit cmd,
                         input logic [AW-1:0] a,
                         input logic [WW-1:0] d0, input logic [LANES-1:0] m0,
                         input logic [WW-1:0] d1, input logic [LANES-1:0] m1);
        sweep(last_tag);
        rst_n   = rst_v;
        wr_n    = ~cmd;
        wr_addr = a;
        wr_data = d0;
        wr_bw_n = m0;
        @(posedge k);
        model_edge(rst_v, cmd, a, d0, m0);
        #1;
        wr_data = d1;
        wr_bw_n = m1;
        if (rst_v && cmd) pend_d1 = d1;
        if (rst_v && cmd) pend_m1 = m1;
        @(negedge k);
        #1;
        last_tag = tag;
    endtask

    function automatic logic [WW-1:0] rnd_word();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        for (int w = 0; w < WORDS; w++) known[w] = '0;
        @(negedge k);
        #1;
        // R8: reset cycles, commands ignored.
        for (int c = 0; c < 3; c++)
            cycle("R8", 0, 1, AW'(c), rnd_word(), '0, rnd_word(), '0);
        // R4: fill the array with full-mask bursts (R2 even word, R3 odd word).
        for (int a = 0; a < 2 ** AW; a++)
            cycle("R2_R3_R4", 1, 1, AW'(a), rnd_word(), '0, rnd_word(), '0);
        cycle("R6", 1, 0, '0, '0, '1, '0, '1);
        // R1: command low is absent; all masks low must do nothing.
        for (int c = 0; c < 4; c++)
            cycle("R1", 1, 0, AW'(c), rnd_word(), '0, rnd_word(), '0);
        // R4: one lane per beat, different lanes per beat.
        for (int i = 0; i < LANES; i++)
            cycle("R4", 1, 1, AW'(3 + i), rnd_word(), ~(LANES'(1) << i),
                  rnd_word(), ~(LANES'(1) << ((i + 1) % LANES)));
        // R5: abort beat 0 only, then beat 1 only, then both.
        cycle("R5", 1, 1, 5'd9, rnd_word(), '1, rnd_word(), '0);
        cycle("R5", 1, 1, 5'd10, rnd_word(), '0, rnd_word(), '1);
        cycle("R5", 1, 1, 5'd11, rnd_word(), '1, rnd_word(), '1);
        cycle("R6", 1, 0, '0, '0, '1, '0, '1);
        // R7: back-to-back to one burst (later wins), then a run of distinct bursts.
        cycle("R7", 1, 1, 5'd12, rnd_word(), '0, rnd_word(), '0);
        cycle("R7", 1, 1, 5'd12, rnd_word(), 4'b1010, rnd_word(), 4'b0101);
        for (int c = 0; c < 6; c++)
            cycle("R7", 1, 1, AW'(20 + c), rnd_word(), '0, rnd_word(), 4'b0011);
        // R8: a command whose commit edge falls in reset is dropped; memory kept.
        cycle("R8", 1, 1, 5'd14, rnd_word(), '0, rnd_word(), '0);
        cycle("R8", 0, 1, 5'd15, rnd_word(), '0, rnd_word(), '0);
        cycle("R8", 1, 0, '0, '0, '1, '0, '1);
        cycle("R8", 1, 0, '0, '0, '1, '0, '1);
        // Mixed traffic over all requirements.
        for (int c = 0; c < 400; c++)
            cycle("R1_R4_R5_R7", 1, ($urandom() % 4) != 0, AW'($urandom()),
                  rnd_word(), LANES'($urandom()), rnd_word(), LANES'($urandom()));
        cycle("R6", 1, 0, '0, '0, '1, '0, '1);
        cycle("R6", 1, 0, '0, '0, '1, '0, '1);
        sweep(last_tag);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule